// File: doc/BRIEF.md
# Command Handoff Synchronizer

This block carries one command across a clock-domain boundary. A command word, a configuration word and a target chip-select mask come from the bus clock domain and are delivered to the serial core clock domain. A single-cycle go pulse on the bus side captures all three values into a holding register and raises a request. The request reaches the core through a two-flop synchronizer. The core state machine then takes the command, and a four-phase request/acknowledge handshake returns the link to idle.

The core takes a new command only while it is not running one. This lets one further command wait in the holding register while the current command runs. On the bus side the block reports whether it can accept a go pulse. A go pulse that arrives while it cannot sets a sticky error flag, and that command is dropped.

Top module: `cmd_handoff`

## Requirements
- R1: After reset, `busReady` is 1, `cmdErr` is 0, `coreValid` is 0 and `coreActive` is 0.
- R2: A go pulse while `busReady` is 1 captures `cmdIn`, `cfgIn` and `csIn`. When the core later takes the command, `coreCmd`, `coreCfg` and `coreCs` show exactly those values.
- R3: `busReady` drops in the bus cycle after an accepted go pulse. It stays low until the whole handshake is idle again: request raised, acknowledge returned, request dropped, acknowledge released. While the core has not taken the command, `busReady` never returns to 1.
- R4: A go pulse while `busReady` is 0 sets `cmdErr` at the next bus edge. `cmdErr` stays set until `errClear` is pulsed. If a rejected go and `errClear` arrive in the same cycle, the set wins.
- R5: A go pulse rejected under R4 is discarded. The command delivered to the core is still the earlier accepted one.
- R6: `coreValid` is 1 only while a synchronized request is pending, not yet acknowledged, and the core is not active. A `coreAccept` while `coreValid` is 0 has no effect on `coreActive` or on the core-side outputs.
- R7: `coreAccept` while `coreValid` is 1 sets `coreActive` at the next core edge and loads the core-side outputs. Those outputs stay stable while `coreActive` is 1. A `coreDone` pulse clears `coreActive` at the next core edge.
- R8: While one command is active, a second go pulse is accepted once `busReady` is back at 1. That command waits, with `coreValid` at 0, until `coreDone`. It is then offered and delivered unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| busClk | input | 1 | Bus-domain clock |
| busRstN | input | 1 | Bus-domain reset, active low |
| goPulse | input | 1 | One-cycle request to launch a command |
| cmdIn | input | CMD_W | Command word |
| cfgIn | input | CFG_W | Configuration word |
| csIn | input | CS_W | Target chip-select mask |
| errClear | input | 1 | Clears the sticky error flag |
| busReady | output | 1 | Handoff idle; a go pulse will be accepted |
| cmdErr | output | 1 | Sticky flag: go pulse seen while not ready |
| coreClk | input | 1 | Core-domain clock |
| coreRstN | input | 1 | Core-domain reset, active low |
| coreAccept | input | 1 | Core state machine takes the offered command |
| coreDone | input | 1 | Core state machine finished the active command |
| coreValid | output | 1 | A command is offered to the core |
| coreActive | output | 1 | A taken command is running |
| coreCmd | output | CMD_W | Command word of the taken command |
| coreCfg | output | CFG_W | Configuration word of the taken command |
| coreCs | output | CS_W | Chip-select mask of the taken command |

## Verification
A request flag left stuck high would keep `busReady` low for good, and the bench's bounded wait for readiness would report it within about a hundred bus cycles. A missing busy gate on the core side would make `coreValid` rise while a command is still active, which the queue test sees as soon as the second request finishes synchronizing. A holding register that loads on rejected pulses would deliver the wrong payload on the very next take. A lost sticky set or a wrong clear priority shows up on `cmdErr` one bus edge after the pulse.

// File: rtl/cmd_handoff_pkg.sv
package cmd_handoff_pkg;

  // Strobes the control sends toward the datapath, one struct per clock domain.
  typedef struct packed {
    logic capture;   // load the holding register from the bus inputs
    logic hold;      // handshake in flight: holding register must not move
  } busStrobe_t;

  typedef struct packed {
    logic load;      // copy the holding register into the core outputs
    logic active;    // core command running: outputs must not move
  } coreStrobe_t;

endpackage

// File: rtl/cmd_sync_bit.sv
module cmd_sync_bit #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rstN,
  input  logic d,
  output logic q
);
  localparam int LAST = STAGES - 1;

  logic [LAST:0] chain;

  generate
    if (STAGES == 1) begin : g_single
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN) chain <= '0;
        else       chain <= d;
      end
    end else begin : g_multi
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN) chain <= '0;
        else       chain <= {chain[LAST-1:0], d};
      end
    end
  endgenerate

  assign q = chain[LAST];
endmodule

// File: rtl/cmd_handoff_ctrl.sv
module cmd_handoff_ctrl
  import cmd_handoff_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic        busClk,
  input  logic        busRstN,
  input  logic        goPulse,
  input  logic        errClear,
  output logic        busReady,
  output logic        cmdErr,
  output busStrobe_t  busStb,
  input  logic        coreClk,
  input  logic        coreRstN,
  input  logic        coreAccept,
  input  logic        coreDone,
  output logic        coreValid,
  output logic        coreActive,
  output coreStrobe_t coreStb
);
  // ---------------- bus domain ----------------
  logic reqQ, errQ, ackSync;
  logic goOk, goBad;

  assign busReady = ~reqQ & ~ackSync;
  assign goOk     = goPulse & busReady;
  assign goBad    = goPulse & ~busReady;

  always_ff @(posedge busClk or negedge busRstN) begin
    if (!busRstN) begin
      reqQ <= 1'b0;
      errQ <= 1'b0;
    end else begin
      if (goOk)         reqQ <= 1'b1;
      else if (ackSync) reqQ <= 1'b0;
      if (goBad)         errQ <= 1'b1;
      else if (errClear) errQ <= 1'b0;
    end
  end

  assign cmdErr         = errQ;
  assign busStb.capture = goOk;
  assign busStb.hold    = reqQ | ackSync;

  // ---------------- core domain ----------------
  logic reqSync, ackQ, activeQ, takeNow;

  cmd_sync_bit #(.STAGES(SYNC_STAGES)) u_reqSync (
    .clk(coreClk), .rstN(coreRstN), .d(reqQ), .q(reqSync)
  );
  cmd_sync_bit #(.STAGES(SYNC_STAGES)) u_ackSync (
    .clk(busClk), .rstN(busRstN), .d(ackQ), .q(ackSync)
  );

  assign coreValid = reqSync & ~ackQ & ~activeQ;
  assign takeNow   = coreValid & coreAccept;

  always_ff @(posedge coreClk or negedge coreRstN) begin
    if (!coreRstN) begin
      ackQ    <= 1'b0;
      activeQ <= 1'b0;
    end else begin
      if (takeNow)       ackQ <= 1'b1;
      else if (!reqSync) ackQ <= 1'b0;
      if (takeNow)       activeQ <= 1'b1;
      else if (coreDone) activeQ <= 1'b0;
    end
  end

  assign coreActive     = activeQ;
  assign coreStb.load   = takeNow;
  assign coreStb.active = activeQ;

  // ---------------- assertions ----------------
  assert_err_set_R4: assert property (@(posedge busClk) disable iff (!busRstN)
    (goPulse && !busReady) |=> cmdErr);

  assert_ready_drop_R3: assert property (@(posedge busClk) disable iff (!busRstN)
    (goPulse && busReady) |=> !busReady);

  assert_req_held_R3: assert property (@(posedge busClk) disable iff (!busRstN)
    $fell(reqQ) |-> $past(ackSync));

  assert_take_sets_active_R7: assert property (@(posedge coreClk) disable iff (!coreRstN)
    takeNow |=> (coreActive && !coreValid));

  assert_ack_until_release_R6: assert property (@(posedge coreClk) disable iff (!coreRstN)
    (ackQ && reqSync) |=> ackQ);
endmodule

// File: rtl/cmd_handoff_data.sv
module cmd_handoff_data
  import cmd_handoff_pkg::*;
#(
  parameter int CMD_W = 32,
  parameter int CFG_W = 24,
  parameter int CS_W  = 4
) (
  input  logic              busClk,
  input  logic              busRstN,
  input  busStrobe_t        busStb,
  input  logic [CMD_W-1:0]  cmdIn,
  input  logic [CFG_W-1:0]  cfgIn,
  input  logic [CS_W-1:0]   csIn,
  input  logic              coreClk,
  input  logic              coreRstN,
  input  coreStrobe_t       coreStb,
  output logic [CMD_W-1:0]  coreCmd,
  output logic [CFG_W-1:0]  coreCfg,
  output logic [CS_W-1:0]   coreCs
);
  localparam int PAY_W = CMD_W + CFG_W + CS_W;

  logic [PAY_W-1:0] heldPay, corePay;

  // Holding register in the bus domain; only an accepted go pulse writes it.
  always_ff @(posedge busClk or negedge busRstN) begin
    if (!busRstN)           heldPay <= '0;
    else if (busStb.capture) heldPay <= {cmdIn, cfgIn, csIn};
  end

  // Core copy: sampled while the holding register is guaranteed stable.
  always_ff @(posedge coreClk or negedge coreRstN) begin
    if (!coreRstN)        corePay <= '0;
    else if (coreStb.load) corePay <= heldPay;
  end

  assign {coreCmd, coreCfg, coreCs} = corePay;

  assert_hold_stable_R5: assert property (@(posedge busClk) disable iff (!busRstN)
    (busStb.hold && $past(busStb.hold)) |-> $stable(heldPay));

  assert_core_stable_R7: assert property (@(posedge coreClk) disable iff (!coreRstN)
    (coreStb.active && !coreStb.load && $past(coreStb.active)) |-> $stable(corePay));
endmodule

// File: rtl/cmd_handoff.sv
module cmd_handoff
  import cmd_handoff_pkg::*;
#(
  parameter int CMD_W       = 32,
  parameter int CFG_W       = 24,
  parameter int CS_W        = 4,
  parameter int SYNC_STAGES = 2
) (
  input  logic             busClk,
  input  logic             busRstN,
  input  logic             goPulse,
  input  logic [CMD_W-1:0] cmdIn,
  input  logic [CFG_W-1:0] cfgIn,
  input  logic [CS_W-1:0]  csIn,
  input  logic             errClear,
  output logic             busReady,
  output logic             cmdErr,
  input  logic             coreClk,
  input  logic             coreRstN,
  input  logic             coreAccept,
  input  logic             coreDone,
  output logic             coreValid,
  output logic             coreActive,
  output logic [CMD_W-1:0] coreCmd,
  output logic [CFG_W-1:0] coreCfg,
  output logic [CS_W-1:0]  coreCs
);
  busStrobe_t  busStb;
  coreStrobe_t coreStb;

  cmd_handoff_ctrl #(.SYNC_STAGES(SYNC_STAGES)) u_ctrl (
    .busClk, .busRstN, .goPulse, .errClear, .busReady, .cmdErr, .busStb,
    .coreClk, .coreRstN, .coreAccept, .coreDone, .coreValid, .coreActive, .coreStb
  );

  cmd_handoff_data #(.CMD_W(CMD_W), .CFG_W(CFG_W), .CS_W(CS_W)) u_data (
    .busClk, .busRstN, .busStb, .cmdIn, .cfgIn, .csIn,
    .coreClk, .coreRstN, .coreStb, .coreCmd, .coreCfg, .coreCs
  );
endmodule

// File: tb/sim_cmd_handoff.sv
`timescale 1ns/1ps
module sim_cmd_handoff;
  localparam int CMD_W = 32, CFG_W = 24, CS_W = 4;

  logic busClk = 0, coreClk = 0, busRstN = 0, coreRstN = 0;
  logic goPulse = 0, errClear = 0, coreAccept = 0, coreDone = 0;
  logic [CMD_W-1:0] cmdIn = '0;
  logic [CFG_W-1:0] cfgIn = '0;
  logic [CS_W-1:0]  csIn = '0;
  logic busReady, cmdErr, coreValid, coreActive;
  logic [CMD_W-1:0] coreCmd;
  logic [CFG_W-1:0] coreCfg;
  logic [CS_W-1:0]  coreCs;

  int compared = 0, mismatched = 0;
  bit finished = 0;
  logic [CMD_W-1:0] expCmd;
  logic [CFG_W-1:0] expCfg;
  logic [CS_W-1:0]  expCs;

  always #5 busClk = ~busClk;
  always #7 coreClk = ~coreClk;

  cmd_handoff u0 (.*);

  task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    compared++;
    if (!ok) begin
      mismatched++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // Bench model of the sticky error flag (R4).
  function automatic logic nextErr(logic cur, logic go, logic rdy, logic clr);
    if (go && !rdy) return 1'b1;
    if (clr) return 1'b0;
    return cur;
  endfunction

  task automatic busGo(input logic [CMD_W-1:0] c, input logic [CFG_W-1:0] f, input logic [CS_W-1:0] s);
    @(negedge busClk);
    goPulse = 1; cmdIn = c; cfgIn = f; csIn = s;
    @(negedge busClk);
    goPulse = 0;
  endtask

  task automatic waitValid(output bit ok);
    ok = 0;
    for (int i = 0; i < 100 && !ok; i++) begin
      @(negedge coreClk);
      if (coreValid) ok = 1;
    end
  endtask

  task automatic waitReady(output bit ok);
    ok = 0;
    for (int i = 0; i < 100 && !ok; i++) begin
      @(negedge busClk);
      if (busReady) ok = 1;
    end
  endtask

  task automatic pulseAccept();
    @(negedge coreClk); coreAccept = 1;
    @(negedge coreClk); coreAccept = 0;
  endtask

  task automatic pulseDone();
    @(negedge coreClk); coreDone = 1;
    @(negedge coreClk); coreDone = 0;
  endtask

  task automatic checkPayload(input string req);
    chk(coreCmd == expCmd, req, 64'(coreCmd), 64'(expCmd));
    chk(coreCfg == expCfg, req, 64'(coreCfg), 64'(expCfg));
    chk(coreCs == expCs, req, 64'(coreCs), 64'(expCs));
  endtask

  initial begin
    repeat (200000) @(posedge busClk);
    if (!finished) begin
      mismatched++;
      $display("FAIL watchdog expired");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
    end
  end

  initial begin
    bit ok;
    logic errModel;
    void'($urandom(32'h5eed_1234));
    repeat (3) @(negedge busClk);
    busRstN = 1; coreRstN = 1;
    @(negedge busClk);

    // R1 reset state
    chk(busReady == 1, "R1 busReady", 64'(busReady), 1);
    chk(cmdErr == 0, "R1 cmdErr", 64'(cmdErr), 0);
    chk(coreValid == 0, "R1 coreValid", 64'(coreValid), 0);
    chk(coreActive == 0, "R1 coreActive", 64'(coreActive), 0);

    // R6 accept with nothing pending is ignored
    pulseAccept();
    chk(coreActive == 0, "R6 idle accept ignored", 64'(coreActive), 0);
    chk(coreCmd == 0, "R6 idle accept no load", 64'(coreCmd), 0);

    // R3 ready stays low while core does not take
    expCmd = 32'hA5A5_0001; expCfg = 24'h00_1234; expCs = 4'b0001;
    busGo(expCmd, expCfg, expCs);
    chk(busReady == 0, "R3 ready drops", 64'(busReady), 0);
    repeat (30) @(negedge busClk);
    chk(busReady == 0, "R3 ready held low", 64'(busReady), 0);

    // R4 set wins over clear in same cycle
    @(negedge busClk);
    goPulse = 1; errClear = 1; cmdIn = 32'hDEAD_BEEF; cfgIn = 24'hFFFFFF; csIn = 4'hF;
    errModel = nextErr(1'b0, 1'b1, busReady, 1'b1);
    @(negedge busClk);
    goPulse = 0; errClear = 0;
    chk(cmdErr == errModel, "R4 set wins", 64'(cmdErr), 64'(errModel));
    @(negedge busClk); errClear = 1;
    @(negedge busClk); errClear = 0;
    chk(cmdErr == 0, "R4 clear", 64'(cmdErr), 0);

    waitValid(ok);
    chk(ok, "R6 valid offered", 64'(ok), 1);
    pulseAccept();
    chk(coreActive == 1, "R7 active after take", 64'(coreActive), 1);
    checkPayload("R5 rejected go discarded");

    // R8 queue one command behind the active one
    waitReady(ok);
    chk(ok && coreActive, "R8 ready while active", 64'(ok), 1);
    busGo(32'h0BAD_CAFE, 24'h55AA55, 4'b0100);
    repeat (20) @(negedge coreClk);
    chk(coreValid == 0, "R8 waits while active", 64'(coreValid), 0);
    pulseAccept();
    checkPayload("R6 accept while invalid ignored");
    pulseDone();
    chk(coreActive == 0, "R7 done clears", 64'(coreActive), 0);
    expCmd = 32'h0BAD_CAFE; expCfg = 24'h55AA55; expCs = 4'b0100;
    waitValid(ok);
    chk(ok, "R8 queued offered", 64'(ok), 1);
    pulseAccept();
    checkPayload("R8 queued delivered");
    waitReady(ok);
    chk(ok, "R3 ready returns", 64'(ok), 1);
    pulseDone();

    // Random traffic: R2, R4, R5, R7
    for (int it = 0; it < 24; it++) begin
      logic doBad;
      expCmd = $urandom; expCfg = CFG_W'($urandom); expCs = CS_W'($urandom);
      doBad = 1'($urandom);
      busGo(expCmd, expCfg, expCs);
      chk(busReady == 0, "R3 ready low after go", 64'(busReady), 0);
      if (doBad) begin
        busGo(~expCmd, ~expCfg, ~expCs);
        chk(cmdErr == 1, "R4 rejected go flags", 64'(cmdErr), 1);
        @(negedge busClk); errClear = 1;
        @(negedge busClk); errClear = 0;
        chk(cmdErr == 0, "R4 cleared", 64'(cmdErr), 0);
      end
      waitValid(ok);
      chk(ok, "R6 offered", 64'(ok), 1);
      repeat ($urandom_range(0, 3)) @(negedge coreClk);
      pulseAccept();
      chk(coreActive == 1, "R7 active", 64'(coreActive), 1);
      checkPayload(doBad ? "R5 payload kept" : "R2 payload delivered");
      waitReady(ok);
      chk(ok, "R3 handshake idle", 64'(ok), 1);
      pulseDone();
      chk(coreActive == 0, "R7 done", 64'(coreActive), 0);
    end

    finished = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end
endmodule